// File: doc/BRIEF.md
# HDLC Transmit Frame Generator

This block turns a stream of packet bytes, marked with start-of-frame and end-of-frame flags, into a serial HDLC bit stream. It is a single-channel transmitter. It advances by one line bit each time its bit enable is high, so the enable can come from a line clock domain crossing or from a rate divider.

Between frames the block sends continuous flags. A frame opens on a flag boundary and carries its payload least-significant bit first. A frame check sequence follows the payload. The sequence is either the 16-bit CCITT CRC or the 32-bit CRC, selected per frame. A closing flag ends the frame. A zero is inserted after every run of five ones inside the frame, and no zero is inserted inside flags or abort sequences.

A frame is cut short with an abort sequence in any of these cases:
- the host asks for an abort;
- the byte source runs dry in the middle of a frame;
- the frame grows past the programmed maximum length;
- the frame ends before reaching the programmed minimum length.

Top module: `hdlc_tx`

## Requirements
- R1: While reset is asserted tx_bit is 1. With no frame pending, the line carries back-to-back flags, each sent as the bit sequence 0,1,1,1,1,1,1,0 (0x7E, least-significant bit first).
- R2: A frame starts only at the end of a complete flag, on a byte presented with in_sof=1. Each payload byte is sent least-significant bit first. The FCS is followed directly by a closing flag.
- R3: The output moves by exactly one bit per cycle in which bit_en is 1. While bit_en is 0, tx_bit holds its value.
- R4: Inside a frame (payload and FCS), after five consecutive ones a 0 is inserted. The framed bit is not lost; it follows the inserted 0. Flags and abort ones are never stuffed.
- R5: With cfg_crc32=0 the FCS is 16 bits: polynomial x^16+x^12+x^5+1, processed in reflected form (0x8408), preset 0xFFFF, complemented, sent least-significant bit first. For the bytes "123456789" the two FCS bytes on the line are 0x6E then 0x90.
- R6: With cfg_crc32=1 the FCS is the 32-bit CRC: reflected polynomial 0xEDB88320, preset 0xFFFFFFFF, complemented, sent least-significant bit first. For "123456789" the FCS bytes are 0x26, 0x39, 0xF4, 0xCB. The CRC mode is captured when a frame starts.
- R7: If in_valid is 0 when the next payload byte is needed (the current byte is not the last), underrun pulses for one cycle and the frame is aborted.
- R8: An abort sequence is eight unstuffed ones followed by idle flags, so a receiver sees at least seven consecutive ones.
- R9: abort_req=1 while a frame is in its payload or FCS aborts the frame, even if bit_en is 0 in that cycle. abort_req while idle has no effect.
- R10: When a frame's byte count has reached cfg_max_len and its current byte is not the last, the frame is aborted and len_err pulses for one cycle. A frame of exactly cfg_max_len bytes is sent normally.
- R11: A frame whose last byte arrives with a byte count below cfg_min_len is aborted and len_err pulses for one cycle. A frame of exactly cfg_min_len bytes is sent normally.
- R12: While idle, a byte offered without in_sof is accepted and dropped. At most one such byte is dropped per flag.
- R13: in_ready is 1 only in cycles where bit_en is 1 and in_valid is 1. A byte is transferred when in_valid and in_ready are both 1 at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Line bit enable, one output bit per high cycle |
| cfg_crc32 | input | 1 | FCS select: 1 = 32-bit CRC, 0 = 16-bit CRC |
| cfg_min_len | input | 16 | Smallest allowed payload byte count |
| cfg_max_len | input | 16 | Largest allowed payload byte count |
| abort_req | input | 1 | Host request to abort the frame in progress |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted this cycle |
| tx_bit | output | 1 | Serial HDLC line bit |
| underrun | output | 1 | One-cycle pulse: frame aborted for lack of data |
| len_err | output | 1 | One-cycle pulse: frame aborted for length out of range |

## Verification
Several properties are checked on every cycle:
- tx_bit holds while bit_en is low;
- a stuffing stall is always followed by a 0 on the line;
- bytes are taken only on enabled cycles with valid data;
- underrun follows only an in-frame cycle with no valid byte;
- a length error never coincides with taking a byte.

Other behaviour can only be shown by decoding the line in the bench scenarios. This covers flag framing, correct stuffing and unstuffing, FCS values in both CRC modes, whole-frame aborts visible as seven or more ones, the minimum and maximum length boundaries, and dropping of unmarked bytes while idle.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  localparam int          CRC_W      = 32;
  localparam int          BYTE_W     = 8;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [31:0] POLY16_REF = 32'h0000_8408;
  localparam logic [31:0] POLY32_REF = 32'hEDB8_8320;
  localparam logic [31:0] PRESET16   = 32'h0000_FFFF;
  localparam logic [31:0] PRESET32   = 32'hFFFF_FFFF;

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             mode32,
  input  logic             din,
  output logic [CRC_W-1:0] crc_next
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] poly;

  // Bit-serial reflected CRC; in 16-bit mode the upper half stays zero.
  always_comb begin
    poly     = mode32 ? POLY32_REF : POLY16_REF;
    crc_next = (crc_q >> 1) ^ (((crc_q[0] ^ din) == 1'b1) ? poly : '0);
    crc_d    = crc_q;
    if (clr) begin
      crc_d = mode32 ? PRESET32 : PRESET16;
    end else if (upd) begin
      crc_d = crc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic raw_bit,
  input  logic stuffable,
  output logic stall,
  output logic tx_bit
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] ones_q;
  logic [CW-1:0] ones_d;
  logic          tx_d;

  assign stall = (ones_q == CW'(RUN));

  always_comb begin
    ones_d = ones_q;
    tx_d   = tx_bit;
    if (bit_en) begin
      if (stall) begin
        tx_d   = 1'b0;
        ones_d = '0;
      end else begin
        tx_d   = raw_bit;
        ones_d = (stuffable && raw_bit) ? ones_q + CW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      tx_bit <= 1'b1;
    end else begin
      ones_q <= ones_d;
      tx_bit <= tx_d;
    end
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              cfg_crc32,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              abort_req,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [CRC_W-1:0]  crc_next,
  output logic              in_ready,
  output logic              raw_bit,
  output logic              stuffable,
  output logic              busy,
  output logic              crc_clr,
  output logic              crc_upd,
  output logic              crc_mode,
  output logic              crc_din,
  output logic              underrun,
  output logic              len_err
);

  localparam int BC_W = $clog2(CRC_W);
  localparam logic [BC_W-1:0] FCS16_LAST = BC_W'(15);
  localparam logic [BC_W-1:0] FCS32_LAST = BC_W'(CRC_W - 1);

  tx_state_e         st_q, st_d;
  logic [CRC_W-1:0]  sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic              eof_q, eof_d;
  logic              m32_q, m32_d;
  logic              pend_q, pend_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              ur_d, le_d;
  logic              byte_end;
  logic              kill;
  logic [BC_W-1:0]   fcs_last;
  logic [CRC_W-1:0]  fcs_word;

  assign byte_end = (bc_q[2:0] == 3'd7);
  assign kill     = abort_req | pend_q;
  assign fcs_last = m32_q ? FCS32_LAST : FCS16_LAST;
  assign fcs_word = m32_q ? ~crc_next : {16'h0000, ~crc_next[15:0]};
  assign busy     = (st_q == ST_DATA) || (st_q == ST_FCS);
  assign crc_mode = (st_q == ST_IDLE) ? cfg_crc32 : m32_q;
  assign crc_din  = sh_q[0];

  // Line bit selection.
  always_comb begin
    raw_bit   = 1'b1;
    stuffable = 1'b0;
    unique case (st_q)
      ST_IDLE:  raw_bit = FLAG_BYTE[bc_q[2:0]];
      ST_DATA,
      ST_FCS: begin
        raw_bit   = sh_q[0];
        stuffable = 1'b1;
      end
      default:  raw_bit = 1'b1;
    endcase
  end

  // Next-state logic.
  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    bc_d     = bc_q;
    eof_d    = eof_q;
    m32_d    = m32_q;
    len_d    = len_q;
    ur_d     = 1'b0;
    le_d     = 1'b0;
    in_ready = 1'b0;
    crc_clr  = 1'b0;
    crc_upd  = 1'b0;
    pend_d   = busy ? (pend_q | abort_req) : 1'b0;

    if (step) begin
      unique case (st_q)
        ST_IDLE: begin
          bc_d = bc_q + BC_W'(1);
          if (byte_end) begin
            bc_d = '0;
            if (in_valid) begin
              in_ready = 1'b1;
              if (in_sof) begin
                st_d    = ST_DATA;
                sh_d    = {{(CRC_W-BYTE_W){1'b0}}, in_data};
                eof_d   = in_eof;
                len_d   = LEN_W'(1);
                m32_d   = cfg_crc32;
                crc_clr = 1'b1;
              end
            end
          end
        end

        ST_DATA: begin
          crc_upd = 1'b1;
          if (kill) begin
            st_d = ST_ABORT;
            bc_d = '0;
          end else if (!byte_end) begin
            sh_d = sh_q >> 1;
            bc_d = bc_q + BC_W'(1);
          end else if (eof_q) begin
            bc_d = '0;
            if (len_q < cfg_min_len) begin
              st_d = ST_ABORT;
              le_d = 1'b1;
            end else begin
              st_d = ST_FCS;
              sh_d = fcs_word;
            end
          end else if (!in_valid) begin
            st_d = ST_ABORT;
            bc_d = '0;
            ur_d = 1'b1;
          end else if (len_q >= cfg_max_len) begin
            st_d = ST_ABORT;
            bc_d = '0;
            le_d = 1'b1;
          end else begin
            in_ready = 1'b1;
            sh_d     = {{(CRC_W-BYTE_W){1'b0}}, in_data};
            eof_d    = in_eof;
            len_d    = len_q + LEN_W'(1);
            bc_d     = '0;
          end
        end

        ST_FCS: begin
          if (kill) begin
            st_d = ST_ABORT;
            bc_d = '0;
          end else if (bc_q == fcs_last) begin
            st_d = ST_IDLE;
            bc_d = '0;
          end else begin
            sh_d = sh_q >> 1;
            bc_d = bc_q + BC_W'(1);
          end
        end

        default: begin
          if (byte_end) begin
            st_d = ST_IDLE;
            bc_d = '0;
          end else begin
            bc_d = bc_q + BC_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sh_q     <= '0;
      bc_q     <= '0;
      eof_q    <= 1'b0;
      m32_q    <= 1'b0;
      pend_q   <= 1'b0;
      len_q    <= '0;
      underrun <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      st_q     <= st_d;
      sh_q     <= sh_d;
      bc_q     <= bc_d;
      eof_q    <= eof_d;
      m32_q    <= m32_d;
      pend_q   <= pend_d;
      len_q    <= len_d;
      underrun <= ur_d;
      len_err  <= le_d;
    end
  end

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_crc32,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              abort_req,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              underrun,
  output logic              len_err
);

  logic             stall;
  logic             step;
  logic             busy;
  logic             raw_bit;
  logic             stuffable;
  logic             crc_clr;
  logic             crc_upd;
  logic             crc_mode;
  logic             crc_din;
  logic [CRC_W-1:0] crc_next;

  assign step = bit_en & ~stall;

  hdlc_tx_framer #(.LEN_W(LEN_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .cfg_crc32   (cfg_crc32),
    .cfg_min_len (cfg_min_len),
    .cfg_max_len (cfg_max_len),
    .abort_req   (abort_req),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .crc_next    (crc_next),
    .in_ready    (in_ready),
    .raw_bit     (raw_bit),
    .stuffable   (stuffable),
    .busy        (busy),
    .crc_clr     (crc_clr),
    .crc_upd     (crc_upd),
    .crc_mode    (crc_mode),
    .crc_din     (crc_din),
    .underrun    (underrun),
    .len_err     (len_err)
  );

  hdlc_tx_crc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (crc_clr),
    .upd      (crc_upd),
    .mode32   (crc_mode),
    .din      (crc_din),
    .crc_next (crc_next)
  );

  hdlc_tx_stuffer #(.RUN(STUFF_RUN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .raw_bit   (raw_bit),
    .stuffable (stuffable),
    .stall     (stall),
    .tx_bit    (tx_bit)
  );

endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic stall,
  input logic busy,
  input logic in_valid,
  input logic in_ready,
  input logic tx_bit,
  input logic underrun,
  input logic len_err
);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stall) |=> (tx_bit == 1'b0));

  p_take_on_enable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);

  p_take_needs_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  p_underrun_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !$past(in_valid));

  p_underrun_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(busy));

  p_len_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !$past(in_ready));

endmodule

bind hdlc_tx hdlc_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .stall    (stall),
  .busy     (busy),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .tx_bit   (tx_bit),
  .underrun (underrun),
  .len_err  (len_err)
);

// File: tb/hdlc_tx_test.sv
module hdlc_tx_test;

  localparam int NV = 11;
  localparam int MIN_LEN = 2;
  localparam int MAX_LEN = 40;
  // Vector table: length, crc32, enable divider, pattern, hold, abort point, outcome
  // outcome: 0 sent, 1 underrun, 2 length error, 3 host abort
  localparam int V_LEN [NV] = '{9, 9, 20, 20, 33, 1, 45, 12, 16, 40, 2};
  localparam int V_M32 [NV] = '{0, 1, 0, 1, 1, 0, 0, 0, 1, 0, 1};
  localparam int V_DIV [NV] = '{1, 1, 1, 3, 1, 2, 1, 1, 2, 2, 1};
  localparam int V_PAT [NV] = '{0, 0, 1, 1, 2, 2, 2, 2, 2, 2, 1};
  localparam int V_HOLD[NV] = '{-1, -1, -1, -1, -1, -1, -1, 5, -1, -1, -1};
  localparam int V_ABRT[NV] = '{-1, -1, -1, -1, -1, -1, -1, -1, 6, -1, -1};
  localparam int V_EXP [NV] = '{0, 0, 0, 0, 0, 2, 2, 1, 3, 0, 0};

  logic        clk;
  logic        rst_n;
  logic        bit_en;
  logic        cfg_crc32;
  logic [15:0] cfg_min_len;
  logic [15:0] cfg_max_len;
  logic        abort_req;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_sof;
  logic        in_eof;
  logic        in_ready;
  logic        tx_bit;
  logic        underrun;
  logic        len_err;

  hdlc_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_crc32(cfg_crc32),
    .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len), .abort_req(abort_req),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .tx_bit(tx_bit), .underrun(underrun), .len_err(len_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Source model
  logic [7:0] src_q [0:127];
  int src_first, src_last, src_limit, src_ptr, abort_at, div, cyc;
  bit abort_done, force_abort, en_q, fire, last_tx;
  int ur_seen, le_seen, stable_bad, ready_bad;

  // Line receiver model
  bit         rx_bits [0:1023];
  logic [7:0] rx_buf [0:127];
  int rx_n, rx_ones, rx_frames, rx_aborts, rx_flags, rx_stuffed, rx_bad, rx_len;
  bit rx_ab;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rx_frame();
    int nb;
    nb = rx_n - 7;
    if ((nb % 8) != 0) begin
      rx_bad++;
    end else begin
      rx_len = nb / 8;
      for (int j = 0; j < rx_len && j < 128; j++)
        for (int k = 0; k < 8; k++) rx_buf[j][k] = rx_bits[j*8+k];
      rx_frames++;
    end
  endtask

  task automatic rx_feed(input logic b);
    if (b) begin
      rx_ones++;
      if (rx_ones == 7) begin
        rx_aborts++;
        rx_ab = 1'b1;
        rx_n = 0;
      end else if (!rx_ab && rx_n < 1024) begin
        rx_bits[rx_n] = 1'b1;
        rx_n++;
      end
    end else begin
      if (rx_ones == 6) begin
        rx_flags++;
        if (!rx_ab && rx_n > 7) rx_frame();
        rx_ab = 1'b0;
        rx_n = 0;
      end else if (rx_ones == 5) begin
        rx_stuffed++;
      end else if (rx_ones < 5 && !rx_ab && rx_n < 1024) begin
        rx_bits[rx_n] = 1'b0;
        rx_n++;
      end
      rx_ones = 0;
    end
  endtask

  task automatic step_cycle();
    @(negedge clk);
    if (en_q) rx_feed(tx_bit);
    else if (tx_bit !== last_tx) stable_bad++;
    last_tx = tx_bit;
    if (underrun) ur_seen++;
    if (len_err) le_seen++;
    if (fire) src_ptr++;
    cyc++;
    bit_en   = ((cyc % div) == 0);
    in_valid = (src_ptr < src_limit);
    in_data  = src_q[src_ptr & 127];
    in_sof   = (src_ptr == src_first);
    in_eof   = (src_ptr == src_last);
    abort_req = force_abort;
    if (abort_at >= 0 && src_ptr == abort_at && !abort_done) begin
      abort_req  = 1'b1;
      abort_done = 1'b1;
    end
    #1;
    fire = in_valid && in_ready;
    if (in_ready && !bit_en) ready_bad++;
    en_q = bit_en;
  endtask

  function automatic logic [7:0] pat_byte(input int pat, input int i);
    if (pat == 0) return 8'h31 + 8'(i);
    if (pat == 1) return 8'hFF;
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic load_src(input int len, input int pat, input int junk, input int hold);
    for (int i = 0; i < junk; i++) src_q[i] = 8'h5A ^ 8'(i);
    for (int i = 0; i < len; i++) src_q[junk + i] = pat_byte(pat, i);
    src_first  = junk;
    src_last   = junk + len - 1;
    src_limit  = (hold >= 0) ? junk + hold : junk + len;
    src_ptr    = 0;
    abort_done = 1'b0;
  endtask

  function automatic logic [31:0] fcs_of(input int first, input int n, input bit m32);
    logic [31:0] c;
    logic fb;
    c = m32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ src_q[first + i][k];
        c  = c >> 1;
        if (fb) c = c ^ (m32 ? 32'hEDB8_8320 : 32'h0000_8408);
      end
    return m32 ? ~c : {16'h0000, ~c[15:0]};
  endfunction

  task automatic run_frame(input int len, input int m32, input int pat, input int junk,
                           input int hold, input int abrt, input int exp, input string req);
    int ev0, fr0, ab0, bad0, ur0, le0, st0, t, nf, mism;
    logic [31:0] fcs, got;
    cfg_crc32 = m32[0];
    abort_at  = (abrt >= 0) ? junk + abrt : -1;
    load_src(len, pat, junk, hold);
    fr0 = rx_frames; ab0 = rx_aborts; bad0 = rx_bad;
    ur0 = ur_seen; le0 = le_seen; st0 = rx_stuffed;
    ev0 = fr0 + ab0 + bad0;
    t = 0;
    while (!((rx_frames + rx_aborts + rx_bad > ev0) && src_ptr >= src_limit) && t < 30000) begin
      step_cycle();
      t++;
    end
    for (int i = 0; i < 24 * div; i++) step_cycle();
    check(rx_bad == bad0, req, "misaligned frame bits", rx_bad - bad0, 0);
    if (exp == 0) begin
      check(rx_frames - fr0 == 1 && rx_aborts == ab0, {req, " R2"}, "good frame count",
            rx_frames - fr0, 1);
      nf = m32 ? 4 : 2;
      check(rx_len == len + nf, {req, " R2"}, "frame length on line", rx_len, len + nf);
      mism = 0;
      for (int i = 0; i < len; i++) if (rx_buf[i] !== src_q[junk + i]) mism++;
      check(mism == 0, {req, " R2"}, "payload byte mismatches", mism, 0);
      fcs = fcs_of(junk, len, m32[0]);
      got = '0;
      for (int i = 0; i < nf; i++) got[i*8 +: 8] = rx_buf[len + i];
      check(got == fcs, m32 ? "R6" : "R5", "fcs value", got, fcs);
      if (pat == 1)
        check(rx_stuffed > st0, "R4", "stuffed zeros in all-ones frame", rx_stuffed - st0, 1);
    end else begin
      check(rx_aborts - ab0 == 1 && rx_frames == fr0, {req, " R8"}, "abort seen on line",
            rx_aborts - ab0, 1);
    end
    check(ur_seen - ur0 == ((exp == 1) ? 1 : 0), req, "underrun pulses",
          ur_seen - ur0, (exp == 1) ? 1 : 0);
    check(le_seen - le0 == ((exp == 2) ? 1 : 0), req, "len_err pulses",
          le_seen - le0, (exp == 2) ? 1 : 0);
    check(src_ptr == src_limit, req, "source bytes consumed", src_ptr, src_limit);
  endtask

  function automatic string req_of(input int v);
    if (V_EXP[v] == 1) return "R7";
    if (V_EXP[v] == 2) return (V_LEN[v] < MIN_LEN) ? "R11" : "R10";
    if (V_EXP[v] == 3) return "R9";
    if (V_LEN[v] == MAX_LEN) return "R10";
    if (V_LEN[v] == MIN_LEN) return "R11";
    return V_M32[v] ? "R6" : "R5";
  endfunction

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0, a0;
    rst_n = 1'b0; bit_en = 1'b0; cfg_crc32 = 1'b0;
    cfg_min_len = 16'(MIN_LEN); cfg_max_len = 16'(MAX_LEN);
    abort_req = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    src_first = 0; src_last = 0; src_limit = 0; src_ptr = 0; abort_at = -1;
    div = 1; cyc = 0; abort_done = 1'b0; force_abort = 1'b0; en_q = 1'b0; fire = 1'b0;
    ur_seen = 0; le_seen = 0; stable_bad = 0; ready_bad = 0;
    rx_n = 0; rx_ones = 0; rx_frames = 0; rx_aborts = 0; rx_flags = 0;
    rx_stuffed = 0; rx_bad = 0; rx_len = 0; rx_ab = 1'b0;
    repeat (4) @(negedge clk);
    check(tx_bit === 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    check(in_ready === 1'b0, "R13", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    last_tx = tx_bit;

    // R1: idle flags
    f0 = rx_flags;
    for (int i = 0; i < 200; i++) step_cycle();
    check(rx_flags - f0 >= 23, "R1", "idle flag count", rx_flags - f0, 23);
    check(rx_frames == 0 && rx_aborts == 0, "R1", "no frame while idle",
          rx_frames + rx_aborts, 0);

    // R9: abort request while idle is ignored
    a0 = rx_aborts; f0 = rx_flags;
    force_abort = 1'b1;
    for (int i = 0; i < 6; i++) step_cycle();
    force_abort = 1'b0;
    for (int i = 0; i < 100; i++) step_cycle();
    check(rx_aborts == a0, "R9", "abort while idle", rx_aborts - a0, 0);
    check(rx_flags - f0 >= 12, "R9", "flags continue after idle abort_req", rx_flags - f0, 12);

    // Table of frame scenarios
    for (int v = 0; v < NV; v++) begin
      div = V_DIV[v];
      run_frame(V_LEN[v], V_M32[v], V_PAT[v], 0, V_HOLD[v], V_ABRT[v], V_EXP[v], req_of(v));
      if (v == 0)
        check(rx_buf[9] == 8'h6E && rx_buf[10] == 8'h90, "R5", "check-string fcs",
              {rx_buf[10], rx_buf[9]}, 16'h906E);
      if (v == 1)
        check({rx_buf[12], rx_buf[11], rx_buf[10], rx_buf[9]} == 32'hCBF43926, "R6",
              "check-string fcs", {rx_buf[12], rx_buf[11], rx_buf[10], rx_buf[9]},
              32'hCBF43926);
    end

    // R12: unmarked bytes while idle are dropped
    div = 1;
    run_frame(6, 0, 2, 3, -1, -1, 0, "R12");

    // R3: slow enable, output holds between enables
    div = 7;
    run_frame(5, 1, 1, 0, -1, -1, 0, "R3");
    check(stable_bad == 0, "R3", "tx_bit changes without bit_en", stable_bad, 0);
    check(ready_bad == 0, "R13", "in_ready without bit_en", ready_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule